// File: doc/BRIEF.md
# Display Attribute Timing Generator

This block turns one master tick stream into every display-rate gate that an eight-digit LED dot-matrix display needs. A sub-frame slot counter produces a brightness duty gate, and a long divider produces a slow phase of about 2 Hz at a nominal master rate of about 57.3 kHz. The block combines the two with the per-digit flash bits and the attribute fields of the control word. The result is one registered column-enable bit for each digit, which the row and column drivers use to switch that digit's columns on or off.

The master tick comes from a local oscillator or from a shared clock line, and a select pin chooses between them. The display that owns the oscillator drives its tick back out for its neighbours. Displays that share one tick line and one synchronous reset run their counters in lockstep, so their flashing and blinking stay in phase. All logic runs in the single `clk` domain, and each tick is a one-cycle enable.

Top module: `disp_attr_timer`

## Requirements
- R1: While `rst` is high, `digit_en` is all zeros. Reset sets the slot counter to 0, the slow-phase divider to 0 and the phase to visible.
- R2: A sub-frame is 15 master ticks, numbered slot 0 to 14. Brightness code c lights a digit only in slots below N(c). N for codes 0 to 7 is 15, 12, 8, 6, 4, 3, 2 and 0, so code 7 never lights any digit.
- R3: The slow phase starts visible after reset. It inverts after every 14336 master ticks (64 frames of 224 ticks), so a full visible-plus-hidden period is 28672 ticks.
- R4: With `flash_en`=1 and `blink_en`=0, bit i of `flash_bits` set to 1 turns `digit_en[i]` off during the hidden phase. Digits whose bit is 0 are unaffected.
- R5: With `flash_en`=0, the value of `flash_bits` has no effect on `digit_en`.
- R6: With `blink_en`=1, all eight digits are off during the hidden phase, whatever `flash_en` and `flash_bits` are. Blink overrides flash.
- R7: The master tick is `osc_tick` when `clk_sel`=1 and `ext_tick` when `clk_sel`=0. All counters hold in any cycle where the selected tick is 0.
- R8: `tick_out` equals the `osc_tick` of the previous cycle when `clk_sel` was 1 in that cycle, and 0 otherwise.
- R9: A synchronous reset asserted mid-run restarts the slot counter at 0 and the phase as visible, whatever state the block was in.
- R10: `digit_en` is registered. Its value after a clock edge depends only on the inputs and counter state sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, shared by cascaded displays |
| clk_sel | input | 1 | 1: use the local oscillator tick and drive it out; 0: use the shared line |
| osc_tick | input | 1 | One-cycle pulse from the local oscillator |
| ext_tick | input | 1 | One-cycle pulse from the shared clock line |
| tick_out | output | 1 | Registered oscillator tick driven towards other displays |
| bright_code | input | 3 | Brightness code, 0 = full, 7 = blank |
| flash_en | input | 1 | Enables per-digit flashing |
| blink_en | input | 1 | Enables whole-display blinking |
| flash_bits | input | 8 | Per-digit flash marks, bit i for digit i |
| digit_en | output | 8 | Registered column enable, bit i for digit i |

## Verification
Both outputs come from a single register stage, so each result appears at the first clock edge after the inputs and counter state that determine it. The bench applies every stimulus just after a rising edge. At the falling edge it computes the value due at the next rising edge, from its own slot and phase count, and queues it. At the following falling edge it pops that value and compares it with the output, so every comparison lands exactly one register stage after its cause. The flash and blink runs cross the 14336-tick phase boundary in both directions, so the hidden half is observed as it arrives and as it ends.

// File: rtl/dat_pkg.sv
package dat_pkg;

  // Ticks of the sub-frame during which a digit is lit, per brightness code.
  function automatic logic [3:0] on_slots(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'd0:    n = 4'd15;
      3'd1:    n = 4'd12;
      3'd2:    n = 4'd8;
      3'd3:    n = 4'd6;
      3'd4:    n = 4'd4;
      3'd5:    n = 4'd3;
      3'd6:    n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dat_tick_sel.sv
module dat_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic clk_sel,
  input  logic osc_tick,
  input  logic ext_tick,
  output logic mtick,
  output logic tick_out
);

  assign mtick = clk_sel ? osc_tick : ext_tick;

  always_ff @(posedge clk) begin
    if (rst) tick_out <= 1'b0;
    else     tick_out <= clk_sel & osc_tick;
  end

  // R8: a display fed from the shared line never drives it
  p_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
    !clk_sel |=> !tick_out);

  // R8: the oscillator owner repeats its tick one cycle later
  p_follow_osc_r8: assert property (@(posedge clk) disable iff (rst)
    clk_sel |=> (tick_out == $past(osc_tick)));

endmodule

// File: rtl/dat_frame_div.sv
module dat_frame_div #(
  parameter int SLOTS            = 15,
  parameter int FRAME_LEN        = 224,
  parameter int FRAMES_PER_BLINK = 128,
  localparam int SW              = $clog2(SLOTS),
  localparam int HALF_FRAMES     = FRAMES_PER_BLINK / 2,
  localparam int TW              = $clog2(FRAME_LEN),
  localparam int FW              = (HALF_FRAMES > 1) ? $clog2(HALF_FRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mtick,
  output logic [SW-1:0] slot,
  output logic          phase_vis
);

  logic [TW-1:0] tcnt;
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      tcnt      <= '0;
      fcnt      <= '0;
      phase_vis <= 1'b1;
    end else if (mtick) begin
      slot <= (slot == SW'(SLOTS - 1)) ? '0 : slot + 1'b1;
      if (tcnt == TW'(FRAME_LEN - 1)) begin
        tcnt <= '0;
        if (fcnt == FW'(HALF_FRAMES - 1)) begin
          fcnt      <= '0;
          phase_vis <= ~phase_vis;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R2: the slot index stays inside the sub-frame
  p_slot_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(slot) < SLOTS);

  // R7: no selected tick, no movement
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    !mtick |=> ($stable(slot) && $stable(phase_vis)));

  // R9: leaving reset always starts in the visible half at slot 0
  p_reset_visible_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase_vis && slot == '0));

endmodule

// File: rtl/dat_digit_gate.sv
module dat_digit_gate #(
  parameter int NUM_DIGITS = 8,
  parameter int SW         = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SW-1:0]         slot,
  input  logic                  phase_vis,
  input  logic [2:0]            bright_code,
  input  logic                  flash_en,
  input  logic                  blink_en,
  input  logic [NUM_DIGITS-1:0] flash_bits,
  output logic [NUM_DIGITS-1:0] digit_en
);

  logic                  duty_on;
  logic [NUM_DIGITS-1:0] en_next;

  assign duty_on = int'(slot) < int'(dat_pkg::on_slots(bright_code));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic gated;
    // blink gates every digit; flash gates only marked digits when blink is off
    assign gated      = blink_en | (flash_en & flash_bits[g]);
    assign en_next[g] = duty_on & (phase_vis | ~gated);
  end

  always_ff @(posedge clk) begin
    if (rst) digit_en <= '0;
    else     digit_en <= en_next;
  end

  // R2: the blank code lights nothing
  p_blank_r2: assert property (@(posedge clk) disable iff (rst)
    (bright_code == 3'd7) |=> (digit_en == '0));

  // R6: blink in the hidden half darkens the whole display
  p_blink_dark_r6: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !phase_vis) |=> (digit_en == '0));

  // R5: without flash or blink, every digit shares one value
  p_flash_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!flash_en && !blink_en) |=> (digit_en == '0 || digit_en == '1));

endmodule

// File: rtl/disp_attr_timer.sv
module disp_attr_timer #(
  parameter int NUM_DIGITS       = 8,
  parameter int SLOTS            = 15,
  parameter int FRAME_LEN        = 224,
  parameter int FRAMES_PER_BLINK = 128,
  localparam int SW              = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clk_sel,
  input  logic                  osc_tick,
  input  logic                  ext_tick,
  output logic                  tick_out,
  input  logic [2:0]            bright_code,
  input  logic                  flash_en,
  input  logic                  blink_en,
  input  logic [NUM_DIGITS-1:0] flash_bits,
  output logic [NUM_DIGITS-1:0] digit_en
);

  logic          mtick;
  logic [SW-1:0] slot;
  logic          phase_vis;

  dat_tick_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .clk_sel  (clk_sel),
    .osc_tick (osc_tick),
    .ext_tick (ext_tick),
    .mtick    (mtick),
    .tick_out (tick_out)
  );

  dat_frame_div #(
    .SLOTS            (SLOTS),
    .FRAME_LEN        (FRAME_LEN),
    .FRAMES_PER_BLINK (FRAMES_PER_BLINK)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .mtick     (mtick),
    .slot      (slot),
    .phase_vis (phase_vis)
  );

  dat_digit_gate #(
    .NUM_DIGITS (NUM_DIGITS),
    .SW         (SW)
  ) u_gate (
    .clk         (clk),
    .rst         (rst),
    .slot        (slot),
    .phase_vis   (phase_vis),
    .bright_code (bright_code),
    .flash_en    (flash_en),
    .blink_en    (blink_en),
    .flash_bits  (flash_bits),
    .digit_en    (digit_en)
  );

endmodule

// File: tb/sim_disp_attr_timer.sv
module sim_disp_attr_timer;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_TICKS = 14336;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_sel = 1'b1;
  logic       osc_tick = 1'b1;
  logic       ext_tick = 1'b0;
  logic       tick_out;
  logic [2:0] bright_code = 3'd0;
  logic       flash_en = 1'b0;
  logic       blink_en = 1'b0;
  logic [7:0] flash_bits = 8'h00;
  logic [7:0] digit_en;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_attr_timer u0 (
    .clk (clk), .rst (rst), .clk_sel (clk_sel), .osc_tick (osc_tick),
    .ext_tick (ext_tick), .tick_out (tick_out), .bright_code (bright_code),
    .flash_en (flash_en), .blink_en (blink_en), .flash_bits (flash_bits),
    .digit_en (digit_en)
  );

  // reference state, built from the requirements
  int m_slot  = 0;
  int m_half  = 0;
  bit m_phase = 1'b1;
  logic [8:0] exp_q[$];

  function automatic int n_on(input logic [2:0] c);
    case (c)
      3'd0: return 15;  3'd1: return 12;  3'd2: return 8;  3'd3: return 6;
      3'd4: return 4;   3'd5: return 3;   3'd6: return 2;  default: return 0;
    endcase
  endfunction

  // monitor + model: compare what the last edge produced, then predict the next
  always @(negedge clk) begin
    logic [8:0] e;
    logic [7:0] en;
    bit         tick;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (digit_en !== e[7:0]) begin
        errors++;
        $display("FAIL %s digit_en act=%h exp=%h t=%0t", cur_req, digit_en, e[7:0], $time);
      end
      checks++;
      if (tick_out !== e[8]) begin
        errors++;
        $display("FAIL R8 tick_out act=%b exp=%b t=%0t", tick_out, e[8], $time);
      end
    end
    if (rst) begin
      exp_q.push_back(9'h000);
      m_slot = 0; m_half = 0; m_phase = 1'b1;
    end else begin
      for (int i = 0; i < 8; i++)
        en[i] = (m_slot < n_on(bright_code)) &&
                (m_phase || !(blink_en || (flash_en && flash_bits[i])));
      exp_q.push_back({clk_sel & osc_tick, en});
      tick = clk_sel ? osc_tick : ext_tick;
      if (tick) begin
        m_slot = (m_slot == 14) ? 0 : m_slot + 1;
        m_half++;
        if (m_half == HALF_TICKS) begin
          m_half = 0;
          m_phase = !m_phase;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    step(n);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    // R1: outputs cleared while reset is held
    cur_req = "R1";
    step(4);
    rst = 1'b0;
    step(20);

    // R2: every brightness code over two sub-frames
    cur_req = "R2";
    for (int c = 0; c < 8; c++) begin
      bright_code = 3'(c);
      step(30);
    end

    // R10: inputs change every cycle
    cur_req = "R10";
    for (int k = 0; k < 60; k++) begin
      bright_code = 3'($urandom_range(0, 7));
      flash_bits  = 8'($urandom);
      flash_en    = 1'($urandom);
      step(1);
    end
    flash_en = 1'b0;

    // R3, R4: flash on marked digits, crossing into the hidden half
    do_reset(2);
    cur_req = "R3,R4";
    bright_code = 3'd0; flash_en = 1'b1; flash_bits = 8'hA5;
    step(HALF_TICKS + 64);

    // R5: flash disabled while hidden: marks ignored
    cur_req = "R5";
    flash_en = 1'b0; flash_bits = 8'hFF;
    step(200);

    // R6: blink overrides flash, through the end of the hidden half
    cur_req = "R6";
    blink_en = 1'b1; flash_en = 1'b1; flash_bits = 8'h0F; bright_code = 3'd1;
    step(HALF_TICKS - 400);
    cur_req = "R3";
    step(300);
    blink_en = 1'b0; flash_en = 1'b0;

    // R7: shared-line tick with gaps, counters hold on missing ticks
    cur_req = "R7";
    clk_sel = 1'b0; osc_tick = 1'b1; bright_code = 3'd2;
    for (int k = 0; k < 300; k++) begin
      ext_tick = 1'($urandom);
      step(1);
    end
    ext_tick = 1'b0;
    step(50);

    // R8: oscillator owner repeats its tick
    cur_req = "R8";
    clk_sel = 1'b1;
    for (int k = 0; k < 100; k++) begin
      osc_tick = 1'($urandom);
      step(1);
    end
    osc_tick = 1'b1;

    // R9: mid-run reset restarts slot and phase
    cur_req = "R9";
    bright_code = 3'd3; blink_en = 1'b1;
    step(37);
    do_reset(1);
    step(60);

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule